// File: doc/BRIEF.md
# Shadow RAM region attribute controller

This block holds a small set of 16-bit configuration registers behind an I/O port. From their contents it works out how each part of the legacy upper-memory window, 0xA0000 to 0xFFFFF, is handled. For any memory address it reports two things. The first is whether the access is served from internal DRAM (shadowed) or passed to the external bus. The second is whether writes to that address are blocked.

There are two ways to describe the mapping. In the coarse scheme, three bits of the control register at 0x22 each govern a 128 KB region. The video region starting at 0xA0000 also has its own write-access choice. In the fine scheme, which is selected by a mode bit, the register at 0x2E gives each of the eight 32 KB segments from 0xC0000 upward its own enable bit and its own read-only bit.

The mapping is held in registers and changes only when an accepted write arrives. A one-way lock bit freezes the whole configuration until the next reset. The address decode is purely combinational.

Top module: `shadow_attr_ctrl`

## Requirements
- R1: The register set sits at even I/O addresses 0x22, 0x24, 0x26, 0x28, 0x2A, 0x2C and 0x2E. A read with io_rd high returns the stored 16-bit value. After reset, 0x28 holds 0x00F9 and every other register holds 0.
- R2: Writes to any other I/O address, odd addresses included, change neither a register nor the mapping. Reads from those addresses return 0.
- R3: In coarse mode, a write to 0x22 sets the mapping of 0xA0000–0xBFFFF. If bit 10 is 0, the region is external and writable. If bit 10 is 1, the region is internal, and bit 11 selects writable (1) or write-blocked (0).
- R4: In coarse mode, a write to 0x22 makes 0xC0000–0xDFFFF internal and writable when bit 9 is 1, and external otherwise. It makes 0xE0000–0xFFFFF internal and writable when bit 0 is 1, and external otherwise.
- R5: While bit 0 of register 0x2C is 1 (fine mode), a write to 0x22 is stored but leaves the mapping unchanged.
- R6: In fine mode, a write to 0x2E sets segment i (i = 0..7), which covers 0xC0000 + i·0x8000 over 32 KB. Bit i+8 = 0 makes the segment external. Bit i+8 = 1 makes it internal, and bit i selects write-blocked (1) or writable (0). The mapping of 0xA0000–0xBFFFF is left as it was.
- R7: In coarse mode, a write to 0x2E is stored but leaves the mapping unchanged.
- R8: A write to 0x22 with bit 15 set is applied and then locks the block. While locked, every register write is ignored, so neither the stored values nor the mapping change. Only reset clears the lock.
- R9: A mapping change takes effect on the clock edge that accepts the write. The decode outputs follow mem_addr combinationally.
- R10: Addresses below 0xA0000 always report external (internal_sel = 0) and writable (write_block = 0). So does the whole window after reset.
- R11: Writing the mode bit in 0x2C does not change the mapping by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read enable |
| io_addr | input | 8 | I/O register address |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data, 0 when io_rd is low or the address is unmapped |
| mem_addr | input | 20 | Memory address to classify |
| internal_sel | output | 1 | 1 = served from internal DRAM, 0 = external bus |
| write_block | output | 1 | 1 = writes to mem_addr are blocked |

## Verification
Coarse patterns set each enable bit on its own, and then in combination. The bench probes the first, inner and last addresses of each region, which shows whether each bit reaches its own region and no other. In the video region, the write-access bit is tried both with and without the enable bit, to separate read-only from writable shadowing and to show the access bit has no effect on its own. Fine-mode patterns enable a mix of read-only, writable and disabled segments. This shows that the segment indexing is correct and that the coarse video mapping survives. The mode, lock and unmapped-address sequences each write values that would change the mapping if they were wrongly accepted.

// File: rtl/shadow_attr_ctrl.sv
module shadow_attr_ctrl #(
  parameter int          NREG      = 7,
  parameter logic [7:0]  REG_BASE  = 8'h22,
  parameter logic [15:0] INIT_0X28 = 16'h00F9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_addr,
  input  logic [15:0] io_wdata,
  output logic [15:0] io_rdata,
  input  logic [19:0] mem_addr,
  output logic        internal_sel,
  output logic        write_block
);
  localparam int         NSEG     = 12;
  localparam logic [7:0] REG_LAST = REG_BASE + 8'(2 * (NREG - 1));
  localparam int         IDX_CTL  = 0;
  localparam int         IDX_INIT = 3;
  localparam int         IDX_MODE = 5;
  localparam int         IDX_FINE = 6;

  logic [15:0]     cfg [NREG];
  logic [NSEG-1:0] seg_int, seg_wp;
  logic            locked;

  logic [7:0] off;
  logic [2:0] idx;
  logic       hit, fine_mode, accept;
  assign off       = io_addr - REG_BASE;
  assign idx       = off[3:1];
  assign hit       = !io_addr[0] && io_addr >= REG_BASE && io_addr <= REG_LAST;
  assign fine_mode = cfg[IDX_MODE][0];
  assign accept    = io_wr && hit && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++)
        cfg[r] <= (r == IDX_INIT) ? INIT_0X28 : 16'h0000;
      seg_int <= '0;
      seg_wp  <= '0;
      locked  <= 1'b0;
    end else if (accept) begin
      cfg[idx] <= io_wdata;
      if (32'(idx) == IDX_CTL) begin
        if (io_wdata[15]) locked <= 1'b1;
        if (!fine_mode) begin
          for (int s = 0; s < 4; s++) begin
            seg_int[s] <= io_wdata[10];
            seg_wp[s]  <= io_wdata[10] & ~io_wdata[11];
          end
          for (int s = 4; s < 8; s++) begin
            seg_int[s] <= io_wdata[9];
            seg_wp[s]  <= 1'b0;
          end
          for (int s = 8; s < NSEG; s++) begin
            seg_int[s] <= io_wdata[0];
            seg_wp[s]  <= 1'b0;
          end
        end
      end
      if (32'(idx) == IDX_FINE && fine_mode) begin
        for (int k = 0; k < 8; k++) begin
          seg_int[k+4] <= io_wdata[k+8];
          seg_wp[k+4]  <= io_wdata[k+8] & io_wdata[k];
        end
      end
    end
  end

  assign io_rdata = (io_rd && hit) ? cfg[idx] : 16'h0000;

  logic        in_win;
  logic [3:0]  seg;
  logic [15:0] int_pad, wp_pad;
  assign in_win  = mem_addr >= 20'hA0000;
  assign seg     = mem_addr[18:15] + 4'd12;
  assign int_pad = {4'b0000, seg_int};
  assign wp_pad  = {4'b0000, seg_wp};

  assign internal_sel = in_win && int_pad[seg];
  assign write_block  = in_win && wp_pad[seg];

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R8
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && io_wr) |=> ($stable(seg_int) && $stable(seg_wp)));

  // R5
  fine_ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == REG_BASE && fine_mode) |=> ($stable(seg_int) && $stable(seg_wp)));

  // R2
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !hit) |=> ($stable(seg_int) && $stable(seg_wp)));

  // R10
  block_needs_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_block |-> internal_sel);
endmodule

// File: tb/shadow_attr_ctrl_bench.sv
module shadow_attr_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_addr = 8'h00;
  logic [15:0] io_wdata = 16'h0000;
  logic [15:0] io_rdata;
  logic [19:0] mem_addr = 20'h00000;
  logic        internal_sel, write_block;

  int tests = 0, fails = 0;

  shadow_attr_ctrl u_shadow_attr_ctrl (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .mem_addr(mem_addr), .internal_sel(internal_sel), .write_block(write_block)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {io addr, write data, probe address, expected internal, expected block}
  localparam int NV = 18;
  localparam logic [45:0] VEC [NV] = '{
    {8'h22, 16'h0001, 20'hF0000, 1'b1, 1'b0},  // R4 top region on
    {8'h22, 16'h0001, 20'hE8000, 1'b1, 1'b0},  // R4
    {8'h22, 16'h0200, 20'hC4000, 1'b1, 1'b0},  // R4 middle region on
    {8'h22, 16'h0200, 20'hE0000, 1'b0, 1'b0},  // R4 top region now off
    {8'h22, 16'h0400, 20'hA0000, 1'b1, 1'b1},  // R3 shadowed read-only
    {8'h22, 16'h0C00, 20'hBFFFF, 1'b1, 1'b0},  // R3 shadowed read/write
    {8'h22, 16'h0800, 20'hA8000, 1'b0, 1'b0},  // R3 access bit alone
    {8'h22, 16'h0E01, 20'hDFFFF, 1'b1, 1'b0},  // R4 combined
    {8'h22, 16'h0E01, 20'h9FFFF, 1'b0, 1'b0},  // R10 below window
    {8'h2E, 16'h0000, 20'hC8000, 1'b1, 1'b0},  // R7 fine reg in coarse mode
    {8'h2C, 16'h0001, 20'hC0000, 1'b1, 1'b0},  // R11 mode set alone
    {8'h2E, 16'h8180, 20'hF8000, 1'b1, 1'b1},  // R6 segment 7 read-only
    {8'h2E, 16'h8180, 20'hC8000, 1'b0, 1'b0},  // R6 segment 1 disabled
    {8'h2E, 16'h8180, 20'hC0000, 1'b1, 1'b0},  // R6 segment 0 read/write
    {8'h22, 16'h0000, 20'hA4000, 1'b1, 1'b0},  // R5 ctl write ignored
    {8'h2C, 16'h0000, 20'hC8000, 1'b0, 1'b0},  // R11 mode clear alone
    {8'h22, 16'h0201, 20'hC8000, 1'b1, 1'b0},  // R4 coarse again
    {8'h22, 16'h0201, 20'hA0000, 1'b0, 1'b0}   // R3 video off
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic probe(input logic [19:0] a, output logic [1:0] r);
    mem_addr = a;
    #1 r = {internal_sel, write_block};
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [1:0]  r;
    do_reset();

    // R1 reset values
    rd(8'h28, d); check("R1 reset 0x28", d, 16'h00F9);
    rd(8'h22, d); check("R1 reset 0x22", d, 16'h0000);
    rd(8'h2E, d); check("R1 reset 0x2E", d, 16'h0000);
    // R10 reset mapping
    probe(20'hF0000, r); check("R10 reset top", {14'h0, r}, 16'h0000);
    probe(20'hA0000, r); check("R10 reset video", {14'h0, r}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][45:38], VEC[i][37:22]);
      probe(VEC[i][21:2], r);
      check($sformatf("R3/R4/R5/R6/R7/R10/R11 vector %0d", i), {14'h0, r}, {14'h0, VEC[i][1:0]});
    end

    // R1 readback of stored values, including a write the mapping ignored
    rd(8'h2E, d); check("R1 readback 0x2E", d, 16'h8180);
    rd(8'h22, d); check("R1 readback 0x22", d, 16'h0201);
    wr(8'h26, 16'hBEEF);
    rd(8'h26, d); check("R1 readback 0x26", d, 16'hBEEF);
    rd(8'h28, d); check("R1 0x28 kept", d, 16'h00F9);

    // R2 unmapped writes and reads
    wr(8'h23, 16'h0C00);
    wr(8'h30, 16'hFFFF);
    wr(8'h20, 16'h0C00);
    rd(8'h23, d); check("R2 read odd", d, 16'h0000);
    rd(8'h30, d); check("R2 read beyond", d, 16'h0000);
    rd(8'h22, d); check("R2 0x22 untouched", d, 16'h0201);
    probe(20'hA0000, r); check("R2 mapping untouched", {14'h0, r}, 16'h0000);

    // R9 timing: old mapping before the edge, new mapping right after it
    mem_addr = 20'hB0000;
    @(negedge clk);
    io_wr = 1'b1; io_addr = 8'h22; io_wdata = 16'h0401;
    #1 check("R9 before edge", {15'h0, internal_sel}, 16'h0000);
    @(posedge clk);
    #1 check("R9 after edge", {14'h0, internal_sel, write_block}, 16'h0003);
    @(negedge clk);
    io_wr = 1'b0;

    // R8 lock: locking write applies, later writes are dropped
    wr(8'h22, 16'h8001);
    probe(20'hE0000, r); check("R8 locking write applied", {14'h0, r}, 16'h0002);
    probe(20'hA0000, r); check("R8 locking write applied video", {14'h0, r}, 16'h0000);
    wr(8'h22, 16'h0C00);
    wr(8'h2C, 16'h0001);
    wr(8'h2E, 16'hFF00);
    rd(8'h22, d); check("R8 0x22 frozen", d, 16'h8001);
    rd(8'h2C, d); check("R8 0x2C frozen", d, 16'h0000);
    probe(20'hA0000, r); check("R8 video frozen", {14'h0, r}, 16'h0000);
    probe(20'hC8000, r); check("R8 segment frozen", {14'h0, r}, 16'h0000);
    probe(20'hFFFFF, r); check("R8 top frozen", {14'h0, r}, 16'h0002);

    // R8 only reset releases the lock
    do_reset();
    rd(8'h22, d); check("R8 reset clears 0x22", d, 16'h0000);
    probe(20'hF0000, r); check("R8 reset clears mapping", {14'h0, r}, 16'h0000);
    wr(8'h22, 16'h0200);
    probe(20'hD0000, r); check("R8 writable after reset", {14'h0, r}, 16'h0002);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule